// File: doc/BRIEF.md
# Prescaled Timeout Window Monitor

This block watches a window of host clock cycles that opens with a start strobe. If no stop strobe arrives before a programmed limit runs out, it raises an error flag. The limit is a 4-bit cycle number multiplied by one of eight fixed factors chosen by a 3-bit code. The factors span 1 to 1048576, so a single small configuration word can describe windows from one cycle up to about fifteen million cycles.

Inside, the count is split in two. A prescaler divides the host clock by the selected factor. A 4-bit down-counter, loaded with the cycle number, counts the prescaler pulses. The error flag is sticky and drops only when software reads the status. A card-interface data path uses two copies of this block: one times data transfers and the other times completion signals. Both copies use the same configuration layout.

Top module: `timeoutWindow`

## Requirements
- R1: After reset, `busy` and `timeoutErr` are both low.
- R2: The configuration word keeps the cycle number N in bits 3:0 and the factor code C in bits 6:4. Codes 0..7 select factors M of 1, 16, 128, 256, 1024, 4096, 65536 and 1048576.
- R3: The start edge is the clock edge at which `startStrobe` is sampled high. When no stop or restart follows, `timeoutErr` rises and `busy` falls exactly L = N*M clock edges after the start edge.
- R4: A cycle number of zero expires at the first prescaler pulse, that is, M edges after the start edge.
- R5: A stop strobe sampled before expiry ends the window. `busy` is low from the next cycle and `timeoutErr` stays low.
- R6: A start strobe sampled while `busy` is high restarts the window with the full limit, counted from the new start edge.
- R7: `timeoutErr` stays high until an edge at which `statusRead` is sampled high, and it is low after that edge.
- R8: When an expiry and a status read fall on the same edge, `timeoutErr` is high after that edge.
- R9: The configuration word is captured only at the start edge. Changes while `busy` is high do not move the expiry.
- R10: When start and stop are sampled on the same edge, the start wins. The window opens and expires after its full limit.
- R11: `busy` is high in the cycle after every start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWord | input | 7 | Cycle number in bits 3:0, factor code in bits 6:4 |
| startStrobe | input | 1 | Opens or restarts the window |
| stopStrobe | input | 1 | Closes the window before expiry |
| statusRead | input | 1 | Status read; clears the error flag |
| busy | output | 1 | Window currently open |
| timeoutErr | output | 1 | Sticky expiry flag |

## Verification
The assertions check relations that hold on every cycle:
- A start is always followed by `busy`.
- A stop without a start always closes the window.
- The error flag can only rise as the window closes.
- The flag holds until a read.
- A read taken while idle always clears the flag.

Only the bench scenarios can show the exact expiry cycle for each factor code. The same goes for the equivalence of zero and one as cycle numbers, the reload on restart, the configuration being ignored mid-window, and set-over-clear priority when an expiry and a read coincide.

// File: rtl/timeoutWindowPkg.sv
package timeoutWindowPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture configuration, restart counting
    logic clear;  // zero the counters
    logic count;  // advance the prescaler
  } ctlStrobes_t;

  // log2 of the factor chosen by each code
  function automatic int unsigned factorShift(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 4;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 10;
      3'd5:    return 12;
      3'd6:    return 16;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/timeoutDatapath.sv
module timeoutDatapath
  import timeoutWindowPkg::*;
#(
  parameter int CYC_W  = 4,
  parameter int CODE_W = 3,
  parameter int PRE_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [CYC_W-1:0]  cfgCycles,
  input  logic [CODE_W-1:0] cfgCode,
  output logic              tick,
  output logic              lastTick
);

  localparam logic [CYC_W-1:0] ONE_CYC = CYC_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [PRE_W-1:0] loadMask;
  logic [CYC_W-1:0] downCnt;

  // terminal value of the prescaler for the requested factor
  always_comb begin
    loadMask = (PRE_W'(1) << factorShift(3'(cfgCode))) - PRE_W'(1);
  end

  assign tick     = ctl.count && (preCnt == preMask);
  assign lastTick = tick && (downCnt <= ONE_CYC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      preMask <= '0;
      downCnt <= '0;
    end else if (ctl.load) begin
      preCnt  <= '0;
      preMask <= loadMask;
      downCnt <= cfgCycles;
    end else if (ctl.clear) begin
      preCnt  <= '0;
      downCnt <= '0;
    end else if (ctl.count) begin
      if (tick) begin
        preCnt <= '0;
        if (downCnt != '0) downCnt <= downCnt - ONE_CYC;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/timeoutCtrl.sv
module timeoutCtrl
  import timeoutWindowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStrobe,
  input  logic        stopStrobe,
  input  logic        statusRead,
  input  logic        lastTick,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        timeoutErr
);

  logic running;
  logic errFlag;
  logic expire;

  // start beats stop, stop beats expiry
  assign expire = running && lastTick && !startStrobe && !stopStrobe;

  always_comb begin
    ctl.load  = startStrobe;
    ctl.clear = !startStrobe && (stopStrobe || expire);
    ctl.count = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (startStrobe)                running <= 1'b1;
      else if (stopStrobe || expire)  running <= 1'b0;
      // a new expiry wins over a clearing read
      if (expire)                     errFlag <= 1'b1;
      else if (statusRead)            errFlag <= 1'b0;
    end
  end

  assign busy       = running;
  assign timeoutErr = errFlag;

endmodule

// File: rtl/timeoutWindow.sv
module timeoutWindow
  import timeoutWindowPkg::*;
#(
  parameter int CYC_W  = 4,
  parameter int CODE_W = 3,
  parameter int PRE_W  = 20,
  localparam int CFG_W = CYC_W + CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             startStrobe,
  input  logic             stopStrobe,
  input  logic             statusRead,
  output logic             busy,
  output logic             timeoutErr
);

  ctlStrobes_t ctl;
  logic        tick;
  logic        lastTick;

  timeoutCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .stopStrobe (stopStrobe),
    .statusRead (statusRead),
    .lastTick   (lastTick),
    .ctl        (ctl),
    .busy       (busy),
    .timeoutErr (timeoutErr)
  );

  timeoutDatapath #(
    .CYC_W (CYC_W),
    .CODE_W(CODE_W),
    .PRE_W (PRE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cfgCycles(cfgWord[CYC_W-1:0]),
    .cfgCode  (cfgWord[CFG_W-1:CYC_W]),
    .tick     (tick),
    .lastTick (lastTick)
  );

endmodule

// File: rtl/timeoutWindowChk.sv
module timeoutWindowChk (
  input logic clk,
  input logic rstN,
  input logic startStrobe,
  input logic stopStrobe,
  input logic statusRead,
  input logic busy,
  input logic timeoutErr
);

  // R11: a start edge opens the window
  a_r11_start_opens: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> busy);

  // R5: a stop without a start closes the window
  a_r5_stop_closes: assert property (@(posedge clk) disable iff (!rstN)
    (stopStrobe && !startStrobe) |=> !busy);

  // R3: the flag only rises as the window closes
  a_r3_err_on_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $fell(busy));

  // R7: the flag holds until a read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !statusRead) |=> timeoutErr);

  // R7: a read while idle always clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !busy) |=> !timeoutErr);

  // R11: the window opens only on a start
  a_r11_busy_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startStrobe));

endmodule

bind timeoutWindow timeoutWindowChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startStrobe(startStrobe),
  .stopStrobe (stopStrobe),
  .statusRead (statusRead),
  .busy       (busy),
  .timeoutErr (timeoutErr)
);

// File: tb/timeoutWindow_test.sv
module timeoutWindow_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 11;

  // stimulus: configuration word {code, cycles}; expected edges to expiry
  localparam logic [6:0] VEC_CFG [NVEC] = '{
    {3'd0, 4'd1}, {3'd0, 4'd5}, {3'd0, 4'd15}, {3'd0, 4'd0},
    {3'd1, 4'd0}, {3'd1, 4'd3}, {3'd2, 4'd15}, {3'd3, 4'd2},
    {3'd4, 4'd1}, {3'd5, 4'd2}, {3'd6, 4'd1}
  };
  localparam int VEC_LEN [NVEC] = '{
    1, 5, 15, 1, 16, 48, 1920, 512, 1024, 8192, 65536
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] cfgWord = '0;
  logic       startStrobe = 1'b0;
  logic       stopStrobe = 1'b0;
  logic       statusRead = 1'b0;
  logic       busy;
  logic       timeoutErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  timeoutWindow uut (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWord    (cfgWord),
    .startStrobe(startStrobe),
    .stopStrobe (stopStrobe),
    .statusRead (statusRead),
    .busy       (busy),
    .timeoutErr (timeoutErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // start (optionally with stop) sampled at the next edge; returns after it
  task automatic startWin(input logic [6:0] cfg, input logic withStop);
    @(negedge clk);
    cfgWord     = cfg;
    startStrobe = 1'b1;
    stopStrobe  = withStop;
    @(negedge clk);
    startStrobe = 1'b0;
    stopStrobe  = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  // called just after the start edge; checks expiry at edge len
  task automatic expectExpiry(input string req, input int len);
    repeat (len - 1) @(negedge clk);
    check({req, " busy before limit"}, busy, 1'b1);
    check({req, " no error before limit"}, timeoutErr, 1'b0);
    @(negedge clk);
    check({req, " error at limit"}, timeoutErr, 1'b1);
    check({req, " busy ends at limit"}, busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy, 1'b0);
    check("R1 err", timeoutErr, 1'b0);
    rstN = 1'b1;

    // R2 R3 R4: walk the vector table
    for (int i = 0; i < NVEC; i++) begin
      startWin(VEC_CFG[i], 1'b0);
      check("R11 busy after start", busy, 1'b1);
      expectExpiry("R2 R3 R4 table", VEC_LEN[i]);
      readStatus();
      check("R7 cleared by read", timeoutErr, 1'b0);
    end

    // R5: stop before expiry
    startWin({3'd0, 4'd4}, 1'b0);
    repeat (2) @(negedge clk);
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0;
    check("R5 busy after stop", busy, 1'b0);
    repeat (10) @(negedge clk);
    check("R5 no error after stop", timeoutErr, 1'b0);

    // R6: restart reloads the full limit
    startWin({3'd0, 4'd4}, 1'b0);
    repeat (2) @(negedge clk);
    startWin({3'd0, 4'd4}, 1'b0);
    expectExpiry("R6 restart", 4);

    // R7: sticky until a read
    repeat (20) @(negedge clk);
    check("R7 sticky", timeoutErr, 1'b1);

    // R8: expiry coinciding with a read keeps the flag
    startWin({3'd0, 4'd3}, 1'b0);
    @(negedge clk);
    statusRead = 1'b1;           // sampled at the start edge + 2
    @(negedge clk);
    check("R7 read clears while busy", timeoutErr, 1'b0);
    @(negedge clk);              // sampled at start edge + 3 = expiry
    statusRead = 1'b0;
    check("R8 set wins over read", timeoutErr, 1'b1);
    readStatus();
    check("R7 cleared after R8", timeoutErr, 1'b0);

    // R9: configuration ignored while busy
    startWin({3'd0, 4'd2}, 1'b0);
    cfgWord = {3'd2, 4'd15};
    expectExpiry("R9 cfg captured at start", 2);
    readStatus();

    // R10: start and stop together
    startWin({3'd1, 4'd1}, 1'b1);
    check("R10 start wins", busy, 1'b1);
    expectExpiry("R10 full limit", 16);
    readStatus();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule